// File: doc/BRIEF.md
# Overclocking Watchdog with Divider Recovery

This block protects a system that is being overclocked. Software arms a countdown by setting an enable bit. The timeout is a 3-bit multiplier times one of two time units, a short one and a long one. If software does not disarm or retune the countdown before it runs out, the system has probably hung at the new clock setting. The block then pulls an active-low system reset line low for a fixed time and raises an alarm flag.

Together with the reset, the block can present a recovered frequency-divider setting (N and M) with a one-cycle reload strobe, so the frequency logic returns to a known-good point. The recovered setting comes from the hardware-strapped values, from a snapshot taken when the watchdog was armed, or from a software-written N combined with the snapshot M. A fourth policy keeps the present setting. A software reset request produces the same reset pulse without an alarm or a reload. Its busy flag clears itself when the pulse ends.

All time is counted in ticks of a free-running `tick` strobe. The unit lengths and the pulse length are parameters, so any tick rate can be used.

Top module: `ocwd_guard`

## Requirements
- R1: The timeout is `wd_stamp` times the selected unit, counted in `tick` cycles. The unit is UNIT_SHORT_TICKS when `wd_long`=0 and UNIT_LONG_TICKS when `wd_long`=1. Code 000 is a test mode with a one-tick timeout. The countdown advances only on cycles where `tick` is high.
- R2: A 0-to-1 change of `wd_en` loads the timeout and starts the countdown. Driving `wd_en` low before the count ends cancels it, and no reset follows.
- R3: While `wd_en` stays high, a change of `wd_stamp` or `wd_long` restarts the countdown from the new value.
- R4: On expiry, `sys_rst_n` goes low at the second clock edge after the tick that ends the count. It stays low for PULSE_TICKS ticks.
- R5: Expiry sets `alarm`. `alarm` stays set until a cycle with `alarm_clr` high. If both happen in the same cycle, the set wins.
- R6: After an expiry the watchdog stays idle, with no further pulse, until `wd_stamp` or `wd_long` changes or `wd_en` falls and rises again.
- R7: With `reset_only`=0, a watchdog pulse comes with a one-cycle `reload_stb` in its first low cycle. With `reset_only`=1 there is no strobe and `rec_n`/`rec_m` keep their values.
- R8: `rec_policy` picks the recovered setting. 00 gives `hw_n`/`hw_m`. 01 gives `cur_n`/`cur_m` as sampled when `wd_en` rose. 10 gives `man_n` with the M sampled when `wd_en` rose. 11 gives `cur_n`/`cur_m` at expiry.
- R9: A one-cycle `sw_rst_req` drives `sys_rst_n` low from the next clock edge for PULSE_TICKS ticks. It does not set `alarm` or assert `reload_stb`. `sw_rst_busy` is high during that pulse and clears itself when the pulse ends.
- R10: After reset, `sys_rst_n`=1, `alarm`=0, `reload_stb`=0, `sw_rst_busy`=0 and `rec_n`=`rec_m`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Free-running time-base strobe |
| wd_en | input | 1 | Watchdog enable |
| wd_stamp | input | 3 | Timeout multiplier |
| wd_long | input | 1 | Time-unit select, 1 = long |
| reset_only | input | 1 | 1 = pulse only, 0 = pulse plus reload |
| rec_policy | input | 2 | Recovery policy |
| man_n | input | N_W | Software recovery N |
| hw_n | input | N_W | Strapped N |
| hw_m | input | M_W | Strapped M |
| cur_n | input | N_W | Current N |
| cur_m | input | M_W | Current M |
| sw_rst_req | input | 1 | Software reset request, one cycle after write completion |
| alarm_clr | input | 1 | Clears the alarm flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| alarm | output | 1 | Timeout alarm flag |
| reload_stb | output | 1 | One-cycle divider reload strobe |
| rec_n | output | N_W | Recovered N |
| rec_m | output | M_W | Recovered M |
| sw_rst_busy | output | 1 | Software reset bit, self-clearing |

## Verification
The timeout is swept over every multiplier code with both units, and the reset delay and pulse width are measured. This separates the test-mode code from the real codes and the short unit from the long one. Further runs cover:
- a multiplier change mid-count, which must give the new length rather than the old remainder;
- an early disable, which must give no pulse at all;
- a held-off tick, which must give no progress;
- a long wait after expiry with enable still high, which must give no second pulse.

Each recovery policy runs with the current divider changed after arming, so the snapshot, strap, manual and current sources all give different expected values. The reset-only mode and the software-reset path are then checked for the absence of strobe and alarm.

// File: rtl/ocwd_pkg.sv
package ocwd_pkg;

    typedef enum logic [1:0] {
        POL_STRAP  = 2'b00,
        POL_SNAP   = 2'b01,
        POL_MANUAL = 2'b10,
        POL_KEEP   = 2'b11
    } rec_policy_e;

    localparam int STAMP_W = 3;

endpackage

// File: rtl/ocwd_countdown.sv
module ocwd_countdown
    import ocwd_pkg::*;
#(
    parameter int UNIT_SHORT_TICKS = 294,
    parameter int UNIT_LONG_TICKS  = 2340
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               en,
    input  logic [STAMP_W-1:0] stamp,
    input  logic               long_sel,
    output logic               en_rise,
    output logic               expire
);

    localparam int CW = $clog2(7 * UNIT_LONG_TICKS + 1);
    localparam logic [CW-1:0] U_S = CW'(UNIT_SHORT_TICKS);
    localparam logic [CW-1:0] U_L = CW'(UNIT_LONG_TICKS);

    typedef struct packed {
        logic               en_p;
        logic [STAMP_W-1:0] stamp_p;
        logic               long_p;
        logic               armed;
        logic [CW-1:0]      cnt;
        logic               expire;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic       chg;
    logic [CW-1:0] load_v;

    always_comb begin
        st_d         = st_q;
        st_d.en_p    = en;
        st_d.stamp_p = stamp;
        st_d.long_p  = long_sel;
        st_d.expire  = 1'b0;
        en_rise = en & ~st_q.en_p;
        chg     = en & st_q.en_p & ((stamp != st_q.stamp_p) | (long_sel != st_q.long_p));
        load_v  = (stamp == '0) ? CW'(1) : CW'(stamp) * (long_sel ? U_L : U_S);
        if (!en) begin
            st_d.armed = 1'b0;
        end else if (en_rise || chg) begin
            st_d.armed = 1'b1;
            st_d.cnt   = load_v;
        end else if (st_q.armed && tick) begin
            if (st_q.cnt == CW'(1)) begin
                st_d.armed  = 1'b0;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.expire;

    AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !expire); // R2

    AST_IDLE_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire && $stable(en) && $stable(stamp) && $stable(long_sel) |=> !expire); // R6

endmodule

// File: rtl/ocwd_pulse.sv
module ocwd_pulse #(
    parameter int PULSE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wd_fire,
    input  logic sw_req,
    input  logic reload_ok,
    output logic take,
    output logic active,
    output logic stb,
    output logic sw_busy
);

    localparam int PW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] cnt;
        logic          stb;
        logic          sw_busy;
    } pl_state_t;

    pl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        take     = 1'b0;
        if (!st_q.active) begin
            if (wd_fire || sw_req) begin
                st_d.active  = 1'b1;
                st_d.cnt     = PW'(PULSE_TICKS);
                st_d.sw_busy = sw_req;
                st_d.stb     = wd_fire & reload_ok;
                take         = wd_fire & reload_ok;
            end
        end else if (tick && st_q.cnt == PW'(1)) begin
            st_d.active  = 1'b0;
            st_d.sw_busy = 1'b0;
        end else begin
            if (tick) st_d.cnt = st_q.cnt - PW'(1);
            if (sw_req) st_d.sw_busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign stb     = st_q.stb;
    assign sw_busy = st_q.sw_busy;

    AST_STB_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> active); // R7

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R7

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        active && (st_q.cnt > PW'(1)) |=> active); // R4

    AST_BUSY_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy |-> active); // R9

endmodule

// File: rtl/ocwd_restore.sv
module ocwd_restore
    import ocwd_pkg::*;
#(
    parameter int N_W = 9,
    parameter int M_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           snap_en,
    input  logic           take,
    input  logic [1:0]     policy,
    input  logic [N_W-1:0] hw_n,
    input  logic [M_W-1:0] hw_m,
    input  logic [N_W-1:0] cur_n,
    input  logic [M_W-1:0] cur_m,
    input  logic [N_W-1:0] man_n,
    output logic [N_W-1:0] rec_n,
    output logic [M_W-1:0] rec_m
);

    typedef struct packed {
        logic [N_W-1:0] snap_n;
        logic [M_W-1:0] snap_m;
        logic [N_W-1:0] rec_n;
        logic [M_W-1:0] rec_m;
    } rs_state_t;

    rs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap_en) begin
            st_d.snap_n = cur_n;
            st_d.snap_m = cur_m;
        end
        if (take) begin
            case (rec_policy_e'(policy))
                POL_STRAP:  begin st_d.rec_n = hw_n;        st_d.rec_m = hw_m;        end
                POL_SNAP:   begin st_d.rec_n = st_q.snap_n; st_d.rec_m = st_q.snap_m; end
                POL_MANUAL: begin st_d.rec_n = man_n;       st_d.rec_m = st_q.snap_m; end
                default:    begin st_d.rec_n = cur_n;       st_d.rec_m = cur_m;       end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_n = st_q.rec_n;
    assign rec_m = st_q.rec_m;

    AST_REC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rec_n) && $stable(rec_m)); // R8

endmodule

// File: rtl/ocwd_guard.sv
module ocwd_guard
    import ocwd_pkg::*;
#(
    parameter int UNIT_SHORT_TICKS = 294,
    parameter int UNIT_LONG_TICKS  = 2340,
    parameter int PULSE_TICKS      = 20,
    parameter int N_W              = 9,
    parameter int M_W              = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           wd_en,
    input  logic [2:0]     wd_stamp,
    input  logic           wd_long,
    input  logic           reset_only,
    input  logic [1:0]     rec_policy,
    input  logic [N_W-1:0] man_n,
    input  logic [N_W-1:0] hw_n,
    input  logic [M_W-1:0] hw_m,
    input  logic [N_W-1:0] cur_n,
    input  logic [M_W-1:0] cur_m,
    input  logic           sw_rst_req,
    input  logic           alarm_clr,
    output logic           sys_rst_n,
    output logic           alarm,
    output logic           reload_stb,
    output logic [N_W-1:0] rec_n,
    output logic [M_W-1:0] rec_m,
    output logic           sw_rst_busy
);

    logic en_rise, expire, take, active;
    logic alarm_d, alarm_q;

    ocwd_countdown #(
        .UNIT_SHORT_TICKS(UNIT_SHORT_TICKS),
        .UNIT_LONG_TICKS (UNIT_LONG_TICKS)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en      (wd_en),
        .stamp   (wd_stamp),
        .long_sel(wd_long),
        .en_rise (en_rise),
        .expire  (expire)
    );

    ocwd_pulse #(
        .PULSE_TICKS(PULSE_TICKS)
    ) pulse_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wd_fire  (expire),
        .sw_req   (sw_rst_req),
        .reload_ok(~reset_only),
        .take     (take),
        .active   (active),
        .stb      (reload_stb),
        .sw_busy  (sw_rst_busy)
    );

    ocwd_restore #(
        .N_W(N_W),
        .M_W(M_W)
    ) rest_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .snap_en(en_rise),
        .take   (take),
        .policy (rec_policy),
        .hw_n   (hw_n),
        .hw_m   (hw_m),
        .cur_n  (cur_n),
        .cur_m  (cur_m),
        .man_n  (man_n),
        .rec_n  (rec_n),
        .rec_m  (rec_m)
    );

    always_comb begin
        alarm_d = alarm_q;
        if (expire)         alarm_d = 1'b1;
        else if (alarm_clr) alarm_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alarm_q <= 1'b0;
        else        alarm_q <= alarm_d;
    end

    assign alarm     = alarm_q;
    assign sys_rst_n = ~active;

    AST_ALARM_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> alarm); // R5

    AST_RESET_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !sys_rst_n); // R4

    AST_ALARM_ONLY_BY_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm && !expire |=> !alarm); // R9

endmodule

// File: tb/ocwd_guard_tb_top.sv
module ocwd_guard_tb_top;

    localparam int US = 3;
    localparam int UL = 8;
    localparam int P  = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic tick = 1;
    logic wd_en = 0;
    logic [2:0] wd_stamp = 0;
    logic wd_long = 0;
    logic reset_only = 0;
    logic [1:0] rec_policy = 0;
    logic [8:0] man_n = 0, hw_n = 0, cur_n = 0;
    logic [6:0] hw_m = 0, cur_m = 0;
    logic sw_rst_req = 0, alarm_clr = 0;
    logic sys_rst_n, alarm, reload_stb, sw_rst_busy;
    logic [8:0] rec_n;
    logic [6:0] rec_m;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ocwd_guard #(
        .UNIT_SHORT_TICKS(US), .UNIT_LONG_TICKS(UL), .PULSE_TICKS(P),
        .N_W(9), .M_W(7)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wd_en(wd_en), .wd_stamp(wd_stamp),
        .wd_long(wd_long), .reset_only(reset_only), .rec_policy(rec_policy),
        .man_n(man_n), .hw_n(hw_n), .hw_m(hw_m), .cur_n(cur_n), .cur_m(cur_m),
        .sw_rst_req(sw_rst_req), .alarm_clr(alarm_clr), .sys_rst_n(sys_rst_n),
        .alarm(alarm), .reload_stb(reload_stb), .rec_n(rec_n), .rec_m(rec_m),
        .sw_rst_busy(sw_rst_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wait_low(output int n);
        n = 0;
        do begin step(); n++; end while (sys_rst_n && n < 300);
    endtask

    task automatic low_len(output int m, output int stb0);
        stb0 = int'(reload_stb);
        m = 0;
        while (!sys_rst_n && m < 300) begin m++; step(); end
    endtask

    task automatic count_lows(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin step(); if (!sys_rst_n) lows++; end
    endtask

    task automatic clear_alarm();
        alarm_clr = 1; step(); alarm_clr = 0;
    endtask

    function automatic int tlen(input int code, input int lng);
        return (code == 0) ? 1 : code * (lng ? UL : US);
    endfunction

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, m, s, lows;
        repeat (3) @(negedge clk);
        chk("R10 sys_rst_n", int'(sys_rst_n), 1);
        chk("R10 alarm", int'(alarm), 0);
        chk("R10 reload_stb", int'(reload_stb), 0);
        chk("R10 busy", int'(sw_rst_busy), 0);
        chk("R10 rec", int'(rec_n) + int'(rec_m), 0);
        rst_n = 1;
        step();

        // R1 R4 R5 R7: sweep of all codes and both units
        for (int lng = 0; lng < 2; lng++) begin
            for (int code = 0; code < 8; code++) begin
                wd_en = 0; step();
                wd_stamp = 3'(code); wd_long = lng[0]; step();
                wd_en = 1;
                wait_low(n);
                chk($sformatf("R1 delay code=%0d long=%0d", code, lng), n, tlen(code, lng) + 2);
                low_len(m, s);
                chk("R4 pulse width", m, P);
                chk("R7 reload strobe at first low", s, 1);
                chk("R5 alarm set", int'(alarm), 1);
                clear_alarm();
                chk("R5 alarm cleared", int'(alarm), 0);
            end
        end

        // R6: enable still high after expiry, no second pulse
        count_lows(60, lows);
        chk("R6 no pulse while idle", lows, 0);
        wd_stamp = 3'd2; wd_long = 0;
        wait_low(n);
        chk("R6 rearm by stamp change", n, tlen(2, 0) + 2);
        low_len(m, s);
        clear_alarm();

        // R3: restart on change mid-count
        wd_en = 0; step();
        wd_stamp = 3'd7; wd_long = 1; step();
        wd_en = 1;
        for (int i = 0; i < 10; i++) step();
        wd_stamp = 3'd2; wd_long = 0;
        wait_low(n);
        chk("R3 restart length", n, tlen(2, 0) + 2);
        low_len(m, s);
        clear_alarm();

        // R2: early disable cancels
        wd_en = 0; step();
        wd_stamp = 3'd2; step();
        wd_en = 1;
        for (int i = 0; i < 3; i++) step();
        wd_en = 0;
        count_lows(40, lows);
        chk("R2 cancel no pulse", lows, 0);
        chk("R2 cancel no alarm", int'(alarm), 0);

        // R1: count only on tick
        wd_stamp = 3'd1; wd_long = 0; step();
        tick = 0; wd_en = 1;
        count_lows(30, lows);
        chk("R1 no progress without tick", lows, 0);
        tick = 1;
        wait_low(n);
        chk("R1 resume on tick", n, US + 1);
        low_len(m, s);
        clear_alarm();

        // R8: recovery policies
        hw_n = 9'd101; hw_m = 7'd11; man_n = 9'd333;
        for (int pol = 0; pol < 4; pol++) begin
            int en_, em_;
            wd_en = 0; cur_n = 9'd200; cur_m = 7'd22; rec_policy = 2'(pol); step();
            wd_en = 1; step(); step();
            cur_n = 9'd250; cur_m = 7'd33;
            wait_low(n);
            case (pol)
                0: begin en_ = 101; em_ = 11; end
                1: begin en_ = 200; em_ = 22; end
                2: begin en_ = 333; em_ = 22; end
                default: begin en_ = 250; em_ = 33; end
            endcase
            chk($sformatf("R8 rec_n policy=%0d", pol), int'(rec_n), en_);
            chk($sformatf("R8 rec_m policy=%0d", pol), int'(rec_m), em_);
            low_len(m, s);
            clear_alarm();
        end

        // R7: reset only, no strobe, recovered value kept (250/33)
        wd_en = 0; reset_only = 1; rec_policy = 2'd0; step();
        wd_en = 1;
        wait_low(n);
        low_len(m, s);
        chk("R7 no strobe in reset-only", s, 0);
        chk("R7 rec_n kept", int'(rec_n), 250);
        chk("R7 reset-only pulse width", m, P);
        clear_alarm();
        reset_only = 0;

        // R9: software reset
        wd_en = 0; step();
        sw_rst_req = 1; step(); sw_rst_req = 0;
        chk("R9 sw pulse starts", int'(sys_rst_n), 0);
        chk("R9 busy set", int'(sw_rst_busy), 1);
        low_len(m, s);
        chk("R9 sw pulse width", m, P);
        chk("R9 no strobe", s, 0);
        chk("R9 busy self-clears", int'(sw_rst_busy), 0);
        chk("R9 no alarm", int'(alarm), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule